// File: doc/BRIEF.md
# Accumulator Processor Core

This block is a compact byte-wide processor built around a single accumulator, one scratch register and a one-bit zero flag. It steps through a fixed sequence of controller states to fetch an opcode, gather a two-byte address operand when the instruction needs one, and then execute. Every memory access goes through one synchronous byte port. A read returns its data one cycle after the request, so each byte fetched costs a request cycle followed by a capture cycle.

The controller states are ST_FETCH, ST_DECODE, ST_OPLO_REQ, ST_OPLO_CAP, ST_OPHI_REQ, ST_OPHI_CAP, ST_EXEC, ST_LOAD_WAIT and ST_HALT. The transitions are as follows:

- ST_FETCH always goes to ST_DECODE.
- ST_DECODE goes to ST_HALT on an opcode above 0x0F, to ST_OPLO_REQ on a three-byte opcode, and to ST_EXEC otherwise.
- The operand chain runs ST_OPLO_REQ, ST_OPLO_CAP, ST_OPHI_REQ, ST_OPHI_CAP and then ST_EXEC.
- ST_EXEC goes to ST_LOAD_WAIT for a load and to ST_FETCH for every other instruction.
- ST_LOAD_WAIT goes to ST_FETCH.
- ST_HALT stays in ST_HALT until reset.

Top module: `acc_core`

## Requirements
- R1: While reset is low, the program counter, accumulator, scratch register and zero flag are cleared and `halted` is 0. The first cycle after reset issues a read of address 0x0000.
- R2: The opcode map is fixed: 0x00 no-op, 0x01 load, 0x02 store, 0x03 accumulator to scratch, 0x04 scratch to accumulator, 0x05 jump, 0x06 jump if zero, 0x07 jump if not zero, 0x08 add, 0x09 subtract, 0x0A increment, 0x0B clear, 0x0C and, 0x0D or, 0x0E exclusive or, 0x0F invert.
- R3: Opcodes 0x01, 0x02, 0x05, 0x06 and 0x07 are followed by a 16-bit address whose low byte comes first. All other opcodes are a single byte. The program counter always points at the next instruction.
- R4: A read request is never issued in the same cycle as a write. Every read request is followed by a cycle with no read, in which the returned byte is captured.
- R5: Add puts accumulator plus scratch (modulo 256) in the accumulator. Subtract puts accumulator minus scratch there. Both set the zero flag exactly when the result is 0.
- R6: Increment, and, or, exclusive or and invert write their result to the accumulator and set the zero flag exactly when the result is 0.
- R7: Clear makes the accumulator 0 and sets the zero flag to 1.
- R8: No-op, load, store, both register moves and all three jumps leave the zero flag unchanged.
- R9: A load copies the addressed byte into the accumulator. A store writes the accumulator to the addressed byte, and the next cycle is an instruction fetch.
- R10: The plain jump always takes its target. Jump-if-zero takes it only when the flag is 1, and jump-if-not-zero takes it only when the flag is 0. When a conditional jump is not taken, execution continues at the byte after the three-byte jump.
- R11: An opcode above 0x0F raises `halted`. From then until reset, no read or write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 16 | Byte address for the current read or write |
| mem_rd | output | 1 | Read request; data expected on mem_rdata one cycle later |
| mem_wr | output | 1 | Write request for mem_wdata at mem_addr |
| mem_wdata | output | 8 | Byte to be written (the accumulator) |
| mem_rdata | input | 8 | Byte returned for the read requested in the previous cycle |
| halted | output | 1 | High once an undefined opcode has stopped the core |
| flag_z | output | 1 | Current value of the zero flag |

## Verification
The bench builds the core with its default 8-bit data width, which gives a 16-bit address. This makes wrap-around corners such as 0xFF plus one and 0x03 minus 0x05 reachable, and it gives operand high bytes that differ from the low bytes. The data and jump targets are placed at addresses such as 0x0300 and 0x0120, so a swapped operand byte order lands on a different location and shows up in the stored results. The bench also runs a loop that sums the integers one to five, which exercises a backward conditional jump taken several times before it finally falls through.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

    // R2: fixed opcode map (low nibble of the opcode byte)
    typedef enum logic [3:0] {
        OP_NOP  = 4'h0,
        OP_LDAC = 4'h1,
        OP_STAC = 4'h2,
        OP_MVAC = 4'h3,
        OP_MOVR = 4'h4,
        OP_JUMP = 4'h5,
        OP_JMPZ = 4'h6,
        OP_JPNZ = 4'h7,
        OP_ADD  = 4'h8,
        OP_SUB  = 4'h9,
        OP_INAC = 4'hA,
        OP_CLAC = 4'hB,
        OP_AND  = 4'hC,
        OP_OR   = 4'hD,
        OP_XOR  = 4'hE,
        OP_NOT  = 4'hF
    } opcode_e;

    typedef enum logic [3:0] {
        ST_FETCH,
        ST_DECODE,
        ST_OPLO_REQ,
        ST_OPLO_CAP,
        ST_OPHI_REQ,
        ST_OPHI_CAP,
        ST_EXEC,
        ST_LOAD_WAIT,
        ST_HALT
    } state_e;

    typedef enum logic {
        ASEL_PC,
        ASEL_OPND
    } addr_sel_e;

    typedef struct packed {
        logic      mem_rd;
        logic      mem_wr;
        addr_sel_e asel;
        logic      ld_ir;
        logic      pc_inc;
        logic      ld_lo;
        logic      ld_hi;
        logic      pc_load;
        logic      ld_r;
        logic      alu_en;
        logic      ld_ac_mem;
    } ctl_t;

    localparam int OPCODE_W = 4;

    // R3: opcodes carrying a two-byte address operand
    function automatic logic has_operand(input opcode_e op);
        return (op == OP_LDAC) || (op == OP_STAC) || (op == OP_JUMP) ||
               (op == OP_JMPZ) || (op == OP_JPNZ);
    endfunction

endpackage

// File: rtl/acc_alu.sv
module acc_alu
    import acc_core_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  opcode_e             op,
    input  logic [DATA_W-1:0]   ac,
    input  logic [DATA_W-1:0]   r,
    output logic [DATA_W-1:0]   res,
    output logic                wr_ac,
    output logic                upd_z
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    always_comb begin
        res   = ac;
        wr_ac = 1'b0;
        upd_z = 1'b0;
        unique case (op)
            OP_ADD:  begin res = ac + r;   wr_ac = 1'b1; upd_z = 1'b1; end  // R5
            OP_SUB:  begin res = ac - r;   wr_ac = 1'b1; upd_z = 1'b1; end  // R5
            OP_INAC: begin res = ac + ONE; wr_ac = 1'b1; upd_z = 1'b1; end  // R6
            OP_CLAC: begin res = '0;       wr_ac = 1'b1; upd_z = 1'b1; end  // R7
            OP_AND:  begin res = ac & r;   wr_ac = 1'b1; upd_z = 1'b1; end  // R6
            OP_OR:   begin res = ac | r;   wr_ac = 1'b1; upd_z = 1'b1; end  // R6
            OP_XOR:  begin res = ac ^ r;   wr_ac = 1'b1; upd_z = 1'b1; end  // R6
            OP_NOT:  begin res = ~ac;      wr_ac = 1'b1; upd_z = 1'b1; end  // R6
            OP_MOVR: begin res = r;        wr_ac = 1'b1; upd_z = 1'b0; end  // R8
            default: begin res = ac;       wr_ac = 1'b0; upd_z = 1'b0; end
        endcase
    end

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
    import acc_core_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] fetched,
    input  opcode_e           ir,
    input  logic              z,
    output ctl_t              ctl,
    output logic              halted
);

    state_e  state_q;
    state_e  state_d;
    opcode_e fetched_op;
    logic    fetched_legal;

    assign fetched_op    = opcode_e'(fetched[OPCODE_W-1:0]);
    assign fetched_legal = (fetched[DATA_W-1:OPCODE_W] == '0);  // R11

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FETCH;   // R1
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH:     state_d = ST_DECODE;
            ST_DECODE: begin
                if (!fetched_legal)           state_d = ST_HALT;
                else if (has_operand(fetched_op)) state_d = ST_OPLO_REQ;
                else                          state_d = ST_EXEC;
            end
            ST_OPLO_REQ:  state_d = ST_OPLO_CAP;
            ST_OPLO_CAP:  state_d = ST_OPHI_REQ;
            ST_OPHI_REQ:  state_d = ST_OPHI_CAP;
            ST_OPHI_CAP:  state_d = ST_EXEC;
            ST_EXEC:      state_d = (ir == OP_LDAC) ? ST_LOAD_WAIT : ST_FETCH;
            ST_LOAD_WAIT: state_d = ST_FETCH;
            ST_HALT:      state_d = ST_HALT;
            default:      state_d = ST_HALT;
        endcase
    end

    // outputs
    always_comb begin
        ctl    = '0;
        halted = 1'b0;
        unique case (state_q)
            ST_FETCH: begin
                ctl.mem_rd = 1'b1;
                ctl.asel   = ASEL_PC;
            end
            ST_DECODE: begin
                ctl.ld_ir  = fetched_legal;
                ctl.pc_inc = fetched_legal;   // R3: advanced before execute
            end
            ST_OPLO_REQ, ST_OPHI_REQ: begin
                ctl.mem_rd = 1'b1;
                ctl.asel   = ASEL_PC;
            end
            ST_OPLO_CAP: begin
                ctl.ld_lo  = 1'b1;
                ctl.pc_inc = 1'b1;
            end
            ST_OPHI_CAP: begin
                ctl.ld_hi  = 1'b1;
                ctl.pc_inc = 1'b1;
            end
            ST_EXEC: begin
                unique case (ir)
                    OP_LDAC: begin ctl.mem_rd = 1'b1; ctl.asel = ASEL_OPND; end
                    OP_STAC: begin ctl.mem_wr = 1'b1; ctl.asel = ASEL_OPND; end  // R9
                    OP_JUMP: ctl.pc_load = 1'b1;                                  // R10
                    OP_JMPZ: ctl.pc_load = z;                                     // R10
                    OP_JPNZ: ctl.pc_load = !z;                                    // R10
                    OP_MVAC: ctl.ld_r = 1'b1;
                    OP_NOP:  ctl.alu_en = 1'b0;
                    default: ctl.alu_en = 1'b1;
                endcase
            end
            ST_LOAD_WAIT: ctl.ld_ac_mem = 1'b1;
            ST_HALT:      halted = 1'b1;                                          // R11
            default:      halted = 1'b1;
        endcase
    end

endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_core_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    output logic [2*DATA_W-1:0]   mem_addr,
    output logic                  mem_rd,
    output logic                  mem_wr,
    output logic [DATA_W-1:0]     mem_wdata,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic                  halted,
    output logic                  flag_z
);

    localparam int ADDR_W = 2 * DATA_W;
    localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(1);

    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] ac_q;
    logic [DATA_W-1:0] r_q;
    logic [DATA_W-1:0] oplo_q;
    logic [DATA_W-1:0] ophi_q;
    logic              z_q;
    opcode_e           ir_q;
    logic [ADDR_W-1:0] operand;
    ctl_t              ctl;
    logic [DATA_W-1:0] alu_res;
    logic              alu_wr;
    logic              alu_upd;

    // R3: operand assembled low byte first
    assign operand = {ophi_q, oplo_q};

    acc_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .fetched (mem_rdata),
        .ir      (ir_q),
        .z       (z_q),
        .ctl     (ctl),
        .halted  (halted)
    );

    acc_alu #(.DATA_W(DATA_W)) u_alu (
        .op    (ir_q),
        .ac    (ac_q),
        .r     (r_q),
        .res   (alu_res),
        .wr_ac (alu_wr),
        .upd_z (alu_upd)
    );

    assign mem_addr  = (ctl.asel == ASEL_OPND) ? operand : pc_q;
    assign mem_rd    = ctl.mem_rd;
    assign mem_wr    = ctl.mem_wr;
    assign mem_wdata = ac_q;
    assign flag_z    = z_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin                 // R1
            pc_q   <= '0;
            ac_q   <= '0;
            r_q    <= '0;
            z_q    <= 1'b0;
            oplo_q <= '0;
            ophi_q <= '0;
            ir_q   <= OP_NOP;
        end else begin
            if (ctl.ld_ir) ir_q <= opcode_e'(mem_rdata[OPCODE_W-1:0]);
            if (ctl.pc_load)     pc_q <= operand;
            else if (ctl.pc_inc) pc_q <= pc_q + PC_STEP;
            if (ctl.ld_lo) oplo_q <= mem_rdata;
            if (ctl.ld_hi) ophi_q <= mem_rdata;
            if (ctl.ld_r)  r_q    <= ac_q;
            if (ctl.ld_ac_mem)              ac_q <= mem_rdata;   // R9
            else if (ctl.alu_en && alu_wr)  ac_q <= alu_res;
            if (ctl.alu_en && alu_upd)      z_q  <= (alu_res == '0);
        end
    end

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              halted,
    input logic              flag_z
);

    a_r1_first_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !$past(rst_n)) |-> (mem_rd && mem_addr == '0));

    a_r4_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    a_r4_capture_gap: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    a_r8_store_keeps_z: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> (flag_z == $past(flag_z)));

    a_r9_store_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> (mem_rd && !mem_wr));

    a_r11_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd && !mem_wr));

    a_r11_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

endmodule

bind acc_core acc_core_chk #(.ADDR_W(2 * DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .halted   (halted),
    .flag_z   (flag_z)
);

// File: tb/acc_core_bench.sv
module acc_core_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic        mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        halted;
    logic        flag_z;

    logic [7:0]  mem [0:1023];
    logic        ld_en = 1'b0;
    logic [9:0]  ld_addr = '0;
    logic [7:0]  ld_data = '0;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    acc_core u_acc_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .halted    (halted),
        .flag_z    (flag_z)
    );

    // byte memory with one cycle of read latency
    always @(posedge clk) begin
        if (ld_en)       mem[ld_addr] <= ld_data;
        else if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
        if (mem_rd)      mem_rdata <= mem[mem_addr[9:0]];
    end

    // op, r value, ac value, expected ac, expected z
    localparam int NVEC = 18;
    localparam logic [39:0] VECS [NVEC] = '{
        40'h08_03_05_08_00, 40'h08_01_FF_00_01,
        40'h09_07_07_00_01, 40'h09_05_03_FE_00,
        40'h0A_00_FF_00_01, 40'h0A_99_41_42_00,
        40'h0B_12_55_00_01, 40'h0C_0F_F0_00_01,
        40'h0C_0F_3C_0C_00, 40'h0D_00_00_00_01,
        40'h0D_05_50_55_00, 40'h0E_AA_AA_00_01,
        40'h0E_FF_A5_5A_00, 40'h0F_00_FF_00_01,
        40'h0F_00_0F_F0_00, 40'h04_99_11_99_00,
        40'h04_00_11_00_00, 40'h00_22_33_33_00
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic poke(input int a, input logic [7:0] d);
        ld_en = 1'b1; ld_addr = a[9:0]; ld_data = d;
        @(posedge clk); #1;
        ld_en = 1'b0;
    endtask

    task automatic prep();
        rst_n = 1'b0;
        @(posedge clk); #1;
        for (int a = 0; a < 64; a++)       poke(a, 8'h00);
        for (int a = 'h120; a < 'h130; a++) poke(a, 8'h00);
        for (int a = 'h300; a < 'h320; a++) poke(a, 8'h00);
    endtask

    task automatic run();
        rst_n = 1'b1;
        for (int c = 0; c < 1000 && !halted; c++) begin
            @(posedge clk); #1;
        end
    endtask

    function automatic string req_of(input logic [7:0] op);
        case (op)
            8'h08, 8'h09: return "R5";
            8'h0B:        return "R7";
            8'h04, 8'h00: return "R8";
            default:      return "R6";
        endcase
    endfunction

    task automatic jump_case(input logic [7:0] first, input logic [7:0] jop,
                             input logic [7:0] exp);
        prep();
        poke(0, first);
        poke(1, jop); poke(2, 8'h20); poke(3, 8'h01);
        poke(4, 8'h0A);
        poke(5, 8'h02); poke(6, 8'h00); poke(7, 8'h03);
        poke(8, 8'hFF);
        poke('h120, 8'h0F);
        poke('h121, 8'h02); poke('h122, 8'h00); poke('h123, 8'h03);
        poke('h124, 8'hFF);
        run();
        chk("R10 conditional jump path", {8'h00, mem['h300]}, {8'h00, exp});
    endtask

    initial begin
        #3000000;
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state and first fetch address
        prep();
        poke(0, 8'hFF);
        chk("R1 halted in reset", {15'd0, halted}, 16'd0);
        chk("R1 z in reset", {15'd0, flag_z}, 16'd0);
        rst_n = 1'b1;
        chk("R1 first fetch rd", {15'd0, mem_rd}, 16'd1);
        chk("R1 first fetch addr", mem_addr, 16'h0000);
        run();

        // R5 R6 R7 R8 table walk
        for (int i = 0; i < NVEC; i++) begin
            prep();
            poke(0, 8'h01); poke(1, 8'h01); poke(2, 8'h03);
            poke(3, 8'h03);
            poke(4, 8'h01); poke(5, 8'h02); poke(6, 8'h03);
            poke(7, VECS[i][39:32]);
            poke(8, 8'h02); poke(9, 8'h00); poke(10, 8'h03);
            poke(11, 8'hFF);
            poke('h301, VECS[i][31:24]);
            poke('h302, VECS[i][23:16]);
            run();
            chk({req_of(VECS[i][39:32]), " result"}, {8'h00, mem['h300]},
                {8'h00, VECS[i][15:8]});
            chk({req_of(VECS[i][39:32]), " zero flag"}, {15'd0, flag_z},
                {15'd0, VECS[i][0]});
        end

        // R8 R9 R10: move, clear, no-op and plain jump keep Z=1
        prep();
        poke(0, 8'h01); poke(1, 8'h01); poke(2, 8'h03);
        poke(3, 8'h03); poke(4, 8'h0B); poke(5, 8'h04); poke(6, 8'h00);
        poke(7, 8'h05); poke(8, 8'h0B); poke(9, 8'h00);
        poke(10, 8'hFF);
        poke(11, 8'h02); poke(12, 8'h00); poke(13, 8'h03);
        poke(14, 8'hFF);
        poke('h301, 8'h77);
        run();
        chk("R9 R10 moved value stored", {8'h00, mem['h300]}, 16'h0077);
        chk("R8 z kept at 1", {15'd0, flag_z}, 16'd1);

        // R8 R9: loading zero leaves Z at 0
        prep();
        poke(0, 8'h0A);
        poke(1, 8'h01); poke(2, 8'h01); poke(3, 8'h03);
        poke(4, 8'h02); poke(5, 8'h00); poke(6, 8'h03);
        poke(7, 8'hFF);
        poke('h300, 8'h5C);
        run();
        chk("R9 load of zero stored", {8'h00, mem['h300]}, 16'h0000);
        chk("R8 z kept at 0", {15'd0, flag_z}, 16'd0);

        // R10 R3: conditional jumps, taken and fall-through
        jump_case(8'h0B, 8'h06, 8'hFF);
        jump_case(8'h0A, 8'h06, 8'h02);
        jump_case(8'h0B, 8'h07, 8'h01);
        jump_case(8'h0A, 8'h07, 8'hFE);

        // R5 R10: summation loop 1..5
        prep();
        poke(0, 8'h0B);
        poke(1, 8'h02); poke(2, 8'h10); poke(3, 8'h03);
        poke(4, 8'h02); poke(5, 8'h11); poke(6, 8'h03);
        poke(7, 8'h01); poke(8, 8'h11); poke(9, 8'h03);
        poke(10, 8'h0A);
        poke(11, 8'h02); poke(12, 8'h11); poke(13, 8'h03);
        poke(14, 8'h03);
        poke(15, 8'h01); poke(16, 8'h10); poke(17, 8'h03);
        poke(18, 8'h08);
        poke(19, 8'h02); poke(20, 8'h10); poke(21, 8'h03);
        poke(22, 8'h01); poke(23, 8'h12); poke(24, 8'h03);
        poke(25, 8'h09);
        poke(26, 8'h07); poke(27, 8'h07); poke(28, 8'h00);
        poke(29, 8'hFF);
        poke('h312, 8'h05);
        run();
        chk("R5 R10 loop total", {8'h00, mem['h310]}, 16'd15);
        chk("R10 loop count", {8'h00, mem['h311]}, 16'd5);
        chk("R5 loop final z", {15'd0, flag_z}, 16'd1);

        // R11: undefined opcode halts and nothing after it runs
        prep();
        poke(0, 8'h0A);
        poke(1, 8'h10);
        poke(2, 8'h02); poke(3, 8'h00); poke(4, 8'h03);
        poke(5, 8'hFF);
        run();
        chk("R11 halted raised", {15'd0, halted}, 16'd1);
        repeat (20) begin
            @(posedge clk); #1;
        end
        chk("R11 still halted", {15'd0, halted}, 16'd1);
        chk("R11 no read while halted", {15'd0, mem_rd}, 16'd0);
        chk("R11 no store after halt", {8'h00, mem['h300]}, 16'h0000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule